// File: doc/BRIEF.md
# Video DRAM Cycle Classifier

This block watches the control pins of a dual-port video DRAM and names each memory cycle as it begins. It samples the pin levels twice: once when the row strobe falls and once at the first fall of the column strobe that follows. From those samples it produces a one-cycle, one-hot function code. The codes cover the refresh variants, the register-transfer cycles, the masked, unmasked and block writes, the masked flash write, and the mask and colour register loads. An illegal pattern raises an error pulse instead of a code.

Besides the decode, the block holds the chip's sticky mode state. This is a persistent write-per-bit flag, a stop-point mode flag and a 4-bit stop-point code. Only certain refresh cycles and the mask-register load may change them. A memory controller model or an array front end uses the code to steer its datapath. It also uses a flag that says whether a masked write should apply the stored mask register in place of a mask taken during that cycle.

All pins are sampled on the rising edge of `clk`. A strobe fall is the first clock edge that sees the strobe low after it was seen high. Results are registered and appear in the cycle that follows that edge.

Top module: `vdram_cycle_decoder`

## Requirements
- R1: While `rst` is high and after it is released, `fn_vld`, `fn_code`, `rsv_err`, `use_stored_mask`, `pers_mode` and `stop_mode` are all 0, and `stop_code` is 0.
- R2: The combined column strobe counts as low when `cas_lo_n` or `cas_hi_n` is low, or when both are low. Either strobe on its own gives the same decode.
- R3: If the combined column strobe is low when the row strobe falls, the cycle is a refresh, decoded at that edge. The levels of `we_n` and `sf` select the variant. we_n=0 with sf=1 gives bit 0 (refresh with stop-point load). we_n=1 with sf=0 gives bit 1 (refresh with mode clear). we_n=1 with sf=1 gives bit 2 (refresh that keeps the modes).
- R4: A bit-0 refresh sets `stop_mode` and loads `stop_code` from `addr[7:4]`. The other address bits, 0 to 3 and 8, have no effect.
- R5: A bit-1 refresh clears `pers_mode` and `stop_mode`. A bit-2 refresh leaves both flags and `stop_code` unchanged.
- R6: With the column strobe high and `xfr_n` low at the row fall, the cycle is a transfer. The code appears after the first column fall. (we_n,sf) gives bit 3 for (1,0), bit 4 for (1,1), bit 5 for (0,0) and bit 6 for (0,1).
- R7: With the column strobe high, `xfr_n` high, `we_n` low and `sf` high at the row fall, the code is bit 7 (masked flash write).
- R8: With `xfr_n` high and `sf` low at the row fall, `sf` at the first column fall picks a plain write (0) or a block write (1). `we_n` at the row fall picks masked (0) or unmasked (1). The bits are 8 for masked plain, 9 for masked block, 10 for unmasked plain and 11 for unmasked block.
- R9: With `xfr_n`, `we_n` and `sf` all high at the row fall, `sf` at the first column fall selects the load. A 0 gives bit 12, the mask register load, which also sets `pers_mode`. A 1 gives bit 13, the colour register load.
- R10: `use_stored_mask` is high with the code of a masked write (bits 5, 6, 7, 8 or 9) exactly when `pers_mode` was already set before that cycle. It is 0 for all other cycles.
- R11: The refresh pattern we_n=0, sf=0 raises `rsv_err` for one cycle. It gives no code and changes no mode state.
- R12: Whenever `fn_vld` is high, exactly one bit of `fn_code` is set. Whenever `fn_vld` is low, `fn_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Lower-byte column strobe, active low |
| cas_hi_n | input | 1 | Upper-byte column strobe, active low |
| xfr_n | input | 1 | Transfer / output-enable pin, active low |
| we_n | input | 1 | Write enable, active low |
| sf | input | 1 | Special-function select pin |
| addr | input | 9 | Multiplexed address bus |
| fn_vld | output | 1 | One-cycle pulse: a cycle was classified |
| fn_code | output | 14 | One-hot cycle function (bit map in R3 to R9) |
| rsv_err | output | 1 | One-cycle pulse: reserved pattern seen |
| use_stored_mask | output | 1 | Masked write uses the stored mask register |
| pers_mode | output | 1 | Persistent write-per-bit mode flag |
| stop_mode | output | 1 | Stop-point mode flag |
| stop_code | output | 4 | Stored stop-point code |

## Verification
Each of the fourteen codes is driven once with the modes clear. The masked writes are then driven again after a mask-register load, which shows whether the stored-mask flag follows the persistent flag and not the cycle type alone. The refresh variants come in an order that tells them apart: a stop-point load with noise on the ignored address bits, a keep refresh, a reserved pattern, and then the clearing refresh. After each one, the mode outputs show whether that refresh touched the state. Cycles alternate between the lower and upper column strobes, which exposes a combined strobe that listens to only one pin.

// File: rtl/vdram_pkg.sv
package vdram_pkg;

    localparam int NFUNC = 14;

    typedef enum logic [3:0] {
        F_REF_STOPSET  = 4'd0,
        F_REF_CLR      = 4'd1,
        F_REF_KEEP     = 4'd2,
        F_XFR_RD       = 4'd3,
        F_XFR_SPLIT_RD = 4'd4,
        F_XFR_MWR      = 4'd5,
        F_XFR_MSPLIT   = 4'd6,
        F_FLASH_MWR    = 4'd7,
        F_WR_MASK      = 4'd8,
        F_BLK_MASK     = 4'd9,
        F_WR_PLAIN     = 4'd10,
        F_BLK_PLAIN    = 4'd11,
        F_LOAD_MASK    = 4'd12,
        F_LOAD_COLOR   = 4'd13
    } fn_e;

    // Pin levels captured at the row-strobe fall
    typedef struct packed {
        logic xfr_n;
        logic we_n;
        logic sf;
    } row_snap_t;

    typedef struct packed {
        logic valid;
        logic err;
        fn_e  fn;
    } dec_t;

    function automatic dec_t classify_refresh(input row_snap_t s);
        dec_t d;
        d.valid = 1'b1;
        d.err   = 1'b0;
        d.fn    = F_REF_KEEP;
        unique case ({s.we_n, s.sf})
            2'b00: begin d.valid = 1'b0; d.err = 1'b1; end
            2'b01: d.fn = F_REF_STOPSET;
            2'b10: d.fn = F_REF_CLR;
            default: d.fn = F_REF_KEEP;
        endcase
        return d;
    endfunction

    function automatic dec_t classify_column(input row_snap_t s, input logic sf2);
        dec_t d;
        d.valid = 1'b1;
        d.err   = 1'b0;
        if (!s.xfr_n) begin
            unique case ({s.we_n, s.sf})
                2'b10: d.fn = F_XFR_RD;
                2'b11: d.fn = F_XFR_SPLIT_RD;
                2'b00: d.fn = F_XFR_MWR;
                default: d.fn = F_XFR_MSPLIT;
            endcase
        end else if (!s.we_n && s.sf) begin
            d.fn = F_FLASH_MWR;
        end else if (!s.sf) begin
            if (s.we_n) d.fn = sf2 ? F_BLK_PLAIN : F_WR_PLAIN;
            else        d.fn = sf2 ? F_BLK_MASK  : F_WR_MASK;
        end else begin
            d.fn = sf2 ? F_LOAD_COLOR : F_LOAD_MASK;
        end
        return d;
    endfunction

    function automatic logic is_masked(input fn_e f);
        return (f == F_XFR_MWR) || (f == F_XFR_MSPLIT) || (f == F_FLASH_MWR) ||
               (f == F_WR_MASK) || (f == F_BLK_MASK);
    endfunction

endpackage

// File: rtl/vdram_strobe_tracker.sv
module vdram_strobe_tracker
    import vdram_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ras_n,
    input  logic      cas_lo,
    input  row_snap_t live,
    output logic      ref_evt,
    output logic      col_evt,
    output row_snap_t snap_q
);
    logic ras_prev;
    logic cas_prev;
    logic armed;
    logic ras_fall;
    logic cas_fall;

    assign ras_fall = ras_prev & ~ras_n;
    assign cas_fall = cas_lo & ~cas_prev;
    assign ref_evt  = ras_fall & cas_lo;
    assign col_evt  = armed & cas_fall & ~ras_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
            armed    <= 1'b0;
            snap_q   <= '0;
        end else begin
            ras_prev <= ras_n;
            cas_prev <= cas_lo;
            if (ras_fall && !cas_lo) begin
                armed  <= 1'b1;
                snap_q <= live;
            end else if (col_evt || ras_n) begin
                armed  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vdram_func_decode.sv
module vdram_func_decode
    import vdram_pkg::*;
(
    input  logic      ref_evt,
    input  logic      col_evt,
    input  row_snap_t live,
    input  row_snap_t snap_q,
    input  logic      sf_now,
    output dec_t      dec
);
    always_comb begin
        dec.valid = 1'b0;
        dec.err   = 1'b0;
        dec.fn    = F_REF_STOPSET;
        if (ref_evt)      dec = classify_refresh(live);
        else if (col_evt) dec = classify_column(snap_q, sf_now);
    end
endmodule

// File: rtl/vdram_mode_regs.sv
module vdram_mode_regs
    import vdram_pkg::*;
#(
    parameter int STOP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [STOP_W-1:0] stop_field,
    output logic              pers_mode,
    output logic              stop_mode,
    output logic [STOP_W-1:0] stop_code
);
    logic act;
    assign act = dec.valid & ~dec.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            pers_mode <= 1'b0;
            stop_mode <= 1'b0;
            stop_code <= '0;
        end else if (act) begin
            case (dec.fn)
                F_REF_STOPSET: begin
                    stop_mode <= 1'b1;
                    stop_code <= stop_field;
                end
                F_REF_CLR: begin
                    pers_mode <= 1'b0;
                    stop_mode <= 1'b0;
                end
                F_LOAD_MASK: pers_mode <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vdram_cycle_decoder.sv
module vdram_cycle_decoder
    import vdram_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int STOP_LSB = 4,
    parameter int STOP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_lo_n,
    input  logic              cas_hi_n,
    input  logic              xfr_n,
    input  logic              we_n,
    input  logic              sf,
    input  logic [ADDR_W-1:0] addr,
    output logic              fn_vld,
    output logic [NFUNC-1:0]  fn_code,
    output logic              rsv_err,
    output logic              use_stored_mask,
    output logic              pers_mode,
    output logic              stop_mode,
    output logic [STOP_W-1:0] stop_code
);
    localparam int STOP_MSB = STOP_LSB + STOP_W - 1;

    logic             cas_lo;
    row_snap_t        live;
    row_snap_t        snap_q;
    logic             ref_evt;
    logic             col_evt;
    dec_t             dec;
    logic [NFUNC-1:0] oh_next;

    assign cas_lo = ~(cas_lo_n & cas_hi_n);
    assign live   = '{xfr_n: xfr_n, we_n: we_n, sf: sf};

    vdram_strobe_tracker u_trk (
        .clk     (clk),
        .rst     (rst),
        .ras_n   (ras_n),
        .cas_lo  (cas_lo),
        .live    (live),
        .ref_evt (ref_evt),
        .col_evt (col_evt),
        .snap_q  (snap_q)
    );

    vdram_func_decode u_dec (
        .ref_evt (ref_evt),
        .col_evt (col_evt),
        .live    (live),
        .snap_q  (snap_q),
        .sf_now  (sf),
        .dec     (dec)
    );

    vdram_mode_regs #(.STOP_W(STOP_W)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .stop_field (addr[STOP_MSB:STOP_LSB]),
        .pers_mode  (pers_mode),
        .stop_mode  (stop_mode),
        .stop_code  (stop_code)
    );

    for (genvar g = 0; g < NFUNC; g++) begin : g_oh
        assign oh_next[g] = dec.valid && !dec.err && (dec.fn == fn_e'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fn_vld          <= 1'b0;
            fn_code         <= '0;
            rsv_err         <= 1'b0;
            use_stored_mask <= 1'b0;
        end else begin
            fn_vld          <= dec.valid & ~dec.err;
            fn_code         <= oh_next;
            rsv_err         <= dec.err;
            use_stored_mask <= dec.valid & ~dec.err & is_masked(dec.fn) & pers_mode;
        end
    end
endmodule

// File: rtl/vdram_cycle_decoder_chk.sv
module vdram_cycle_decoder_chk
    import vdram_pkg::*;
#(
    parameter int STOP_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              fn_vld,
    input logic [NFUNC-1:0]  fn_code,
    input logic              rsv_err,
    input logic              use_stored_mask,
    input logic              pers_mode,
    input logic              stop_mode,
    input logic [STOP_W-1:0] stop_code
);
    // R12
    onehot_fn_chk: assert property (@(posedge clk) disable iff (rst)
        fn_vld |-> $countones(fn_code) == 1);

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !fn_vld |-> fn_code == '0);

    // R11
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsv_err |-> !fn_vld && $stable(pers_mode) && $stable(stop_mode) && $stable(stop_code));

    // R9
    pers_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pers_mode) |-> fn_vld && fn_code[F_LOAD_MASK]);

    // R5
    pers_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pers_mode) |-> fn_vld && fn_code[F_REF_CLR]);

    // R4
    code_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stop_code) |-> fn_vld && fn_code[F_REF_STOPSET]);

    // R10
    stored_mask_chk: assert property (@(posedge clk) disable iff (rst)
        use_stored_mask |-> fn_vld && pers_mode);
endmodule

bind vdram_cycle_decoder vdram_cycle_decoder_chk #(.STOP_W(STOP_W)) u_chk (.*);

// File: tb/vdram_cycle_decoder_tb.sv
module vdram_cycle_decoder_tb;
    localparam int NF = 14;
    localparam int VW = NF + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1;
    logic xfr_n = 1'b1, we_n = 1'b1, sf = 1'b0;
    logic [8:0] addr = '0;
    logic fn_vld, rsv_err, use_stored_mask, pers_mode, stop_mode;
    logic [NF-1:0] fn_code;
    logic [3:0] stop_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    // bench-side mode model
    bit       m_pers = 0, m_stop = 0;
    bit [3:0] m_code = 0;

    always #10 clk = ~clk;

    vdram_cycle_decoder u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
        .xfr_n(xfr_n), .we_n(we_n), .sf(sf), .addr(addr),
        .fn_vld(fn_vld), .fn_code(fn_code), .rsv_err(rsv_err),
        .use_stored_mask(use_stored_mask), .pers_mode(pers_mode),
        .stop_mode(stop_mode), .stop_code(stop_code)
    );

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] pack_obs();
        return {fn_vld, fn_code, rsv_err, use_stored_mask, pers_mode, stop_mode, stop_code};
    endfunction

    // Monitor: compare each reported cycle with the next expected item
    always @(negedge clk) begin
        if (!rst && (fn_vld || rsv_err)) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected event", pack_obs(), '0);
            end else begin
                check(tag_q.pop_front(), pack_obs(), exp_q.pop_front());
            end
        end
    end

    // Driver: compute expectation, push it, then wiggle the pins
    task automatic run_cycle(input bit refr, input bit upper, input bit x, input bit w,
                             input bit s1, input bit s2, input logic [8:0] a, input string tag);
        int  idx = -1;
        bit  err = 0, msk = 0, usm;
        logic [NF-1:0] oh = '0;
        if (refr) begin
            case ({w, s1})
                2'b00: err = 1;
                2'b01: idx = 0;
                2'b10: idx = 1;
                default: idx = 2;
            endcase
        end else if (!x) begin
            case ({w, s1})
                2'b10: idx = 3;
                2'b11: idx = 4;
                2'b00: begin idx = 5; msk = 1; end
                default: begin idx = 6; msk = 1; end
            endcase
        end else if (!w && s1) begin
            idx = 7; msk = 1;
        end else if (!s1) begin
            idx = w ? (s2 ? 11 : 10) : (s2 ? 9 : 8);
            msk = !w;
        end else begin
            idx = s2 ? 13 : 12;
        end
        usm = msk && m_pers;
        if (idx == 0) begin m_stop = 1; m_code = a[7:4]; end
        if (idx == 1) begin m_pers = 0; m_stop = 0; end
        if (idx == 12) m_pers = 1;
        if (idx >= 0) oh[idx] = 1'b1;
        exp_q.push_back({!err, oh, err, usm, m_pers, m_stop, m_code});
        tag_q.push_back(tag);

        @(negedge clk);
        if (refr) begin
            if (upper) cas_hi_n = 0; else cas_lo_n = 0;
            repeat (2) @(negedge clk);
            ras_n = 0; xfr_n = x; we_n = w; sf = s1; addr = a;
            repeat (2) @(negedge clk);
            ras_n = 1;
            @(negedge clk);
            cas_lo_n = 1; cas_hi_n = 1;
        end else begin
            ras_n = 0; xfr_n = x; we_n = w; sf = s1; addr = a;
            repeat (2) @(negedge clk);
            sf = s2; addr = ~a;
            if (upper) cas_hi_n = 0; else cas_lo_n = 0;
            repeat (2) @(negedge clk);
            ras_n = 1; cas_lo_n = 1; cas_hi_n = 1;
        end
        xfr_n = 1; we_n = 1; sf = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 in reset", pack_obs(), '0);
        rst = 0;
        repeat (2) @(negedge clk);
        check("R1 after reset", pack_obs(), '0);

        // R6 transfers, modes clear; R2 alternates strobes
        run_cycle(0, 0, 0, 1, 0, 0, 9'h000, "R6 xfer read");
        run_cycle(0, 1, 0, 1, 1, 0, 9'h000, "R6 R2 split read");
        run_cycle(0, 0, 0, 0, 0, 1, 9'h000, "R6 masked xfer write");
        run_cycle(0, 1, 0, 0, 1, 0, 9'h000, "R6 R2 masked split write");
        // R7
        run_cycle(0, 0, 1, 0, 1, 0, 9'h000, "R7 flash write");
        // R8
        run_cycle(0, 1, 1, 0, 0, 0, 9'h000, "R8 masked write");
        run_cycle(0, 0, 1, 0, 0, 1, 9'h000, "R8 masked block");
        run_cycle(0, 1, 1, 1, 0, 0, 9'h000, "R8 plain write");
        run_cycle(0, 0, 1, 1, 0, 1, 9'h000, "R8 plain block");
        // R9
        run_cycle(0, 1, 1, 1, 1, 1, 9'h000, "R9 colour load");
        run_cycle(0, 0, 1, 1, 1, 0, 9'h000, "R9 mask load sets persistent");
        // R10 with persistent mode set
        run_cycle(0, 1, 1, 0, 0, 0, 9'h000, "R10 masked write stored mask");
        run_cycle(0, 0, 1, 0, 1, 0, 9'h000, "R10 flash write stored mask");
        run_cycle(0, 1, 0, 0, 0, 0, 9'h000, "R10 masked xfer stored mask");
        run_cycle(0, 0, 1, 1, 0, 0, 9'h000, "R10 unmasked no stored mask");
        // R3/R4: stop-point load with noise on ignored bits
        run_cycle(1, 0, 1, 0, 1, 0, 9'b1_1010_1111, "R3 R4 stop-point refresh");
        run_cycle(1, 1, 1, 1, 1, 0, 9'b0_0101_0000, "R3 R5 keep refresh");
        run_cycle(1, 0, 1, 0, 0, 0, 9'b0_0011_0000, "R11 reserved refresh");
        run_cycle(1, 1, 1, 1, 0, 0, 9'b0_1111_0000, "R3 R5 clear refresh");
        run_cycle(0, 0, 1, 0, 0, 1, 9'h000, "R10 masked block after clear");
        run_cycle(1, 1, 1, 0, 1, 0, 9'b0_0110_1001, "R4 second stop-point load");

        repeat (4) @(negedge clk);
        // R12: every pushed item was produced
        check("R12 all events seen", VW'(exp_q.size()), '0);
        check("R5 final modes", {pers_mode, stop_mode, stop_code}, {1'b0, 1'b1, 4'h6});
        finish_up();
    end
endmodule